// File: doc/BRIEF.md
# Static Memory Access Timing Sequencer

This block drives one access at a time to an asynchronous static memory device. It produces chip select, output enable, write enable and a data-capture strobe, and counts every wait in memory clock cycles. The wait comes from a 4-bit delay code. A bus-width bit chooses a 32-bit or 16-bit data path. A device-type bit chooses between ordinary static memory, such as flash or SRAM, and variable-latency I/O.

The host starts an access with a one-cycle start pulse. Alongside the pulse it gives the direction, a burst length in 32-bit words, the starting byte address and, for a write, one 32-bit data word. The block samples the configuration fields and the request together, in the cycle it accepts the request. From then on it runs the access by itself. Read words come back one at a time with a valid pulse, and a done pulse closes the access.

A configuration that variable-latency I/O does not allow is flagged with an error pulse, and no access starts. All strobes are active high.

Top module: `smc_access_seq`

## Requirements
- R1: The delay code D maps codes 0 to 11 onto themselves. Codes 12, 13, 14 and 15 map to 13, 15, 18 and 23 cycles.
- R2: On a read to ordinary memory (`cfg_var_lat`=0), the first beat lasts D+2 cycles from chip select, and `mem_capture` pulses in the last of those cycles.
- R3: On such a read, every later beat lasts D+1 cycles, with `mem_oe` held high without a break from the first beat to the last.
- R4: A write moves exactly one host word whatever `req_len` says. Each beat holds `mem_we` high for D+1 cycles, and a one-cycle gap with chip select still high separates beats. On a 16-bit bus, the low half goes out first on `mem_wdata[15:0]` and the high half second.
- R5: On variable-latency I/O (`cfg_var_lat`=1), each read beat holds `mem_oe` high for D+1 cycles, with a one-cycle strobe-low gap between beats and no extra first-beat cycle.
- R6: A request to variable-latency I/O with a delay code below 3 raises `cfg_err` for one cycle, in the cycle after the request. Chip select stays low and no access runs. A code of 3 is accepted.
- R7: `cfg_narrow`=0 selects a 32-bit bus with one beat per word, and `mem_addr` steps by 4 per beat. `cfg_narrow`=1 selects a 16-bit bus with two beats per word, data on `mem_rdata[15:0]`, and `mem_addr` steps by 2 per beat. A read of `req_len`+1 words takes (`req_len`+1)·(1 or 2) beats.
- R8: Chip select rises in the cycle after the request is accepted and stays high until the last beat ends. It then drops for one cycle, in which `done` pulses. A request presented in that `done` cycle is accepted, so chip select is low for exactly one cycle between back-to-back accesses.
- R9: Each completed read word appears on `rd_data` with a one-cycle `rd_valid`, in the cycle after its last capture. On a 16-bit bus the first beat fills bits 15:0 and the second fills bits 31:16.
- R10: Changes to `cfg_*`, `req_*` or `req_start` while an access runs do not affect that access. The timing, address and data follow the values sampled at acceptance.
- R11: While reset is asserted, `mem_cs`, `mem_oe`, `mem_we`, `mem_capture`, `rd_valid`, `done` and `cfg_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dly_code | input | 4 | Delay code D, sampled on acceptance |
| cfg_narrow | input | 1 | Bus width: 0 = 32-bit, 1 = 16-bit |
| cfg_var_lat | input | 1 | Device type: 1 = variable-latency I/O |
| req_start | input | 1 | Request pulse, accepted when idle or in the done cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_len | input | LEN_W | Read burst length in words minus one |
| req_addr | input | ADDR_W | Starting byte address |
| req_wdata | input | DATA_W | Write word |
| mem_rdata | input | DATA_W | Data from the memory device |
| mem_cs | output | 1 | Chip select |
| mem_oe | output | 1 | Output enable |
| mem_we | output | 1 | Write enable |
| mem_capture | output | 1 | Read data sampled at the end of this cycle |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_wdata | output | DATA_W | Write data for the current beat |
| cfg_err | output | 1 | Rejected configuration pulse |
| rd_valid | output | 1 | Read word valid pulse |
| rd_data | output | DATA_W | Assembled read word |
| done | output | 1 | Access complete pulse |

## Verification
The assertions check the following on every cycle:
- `mem_oe` and `mem_we` are never high together.
- No strobe is high while chip select is low.
- A capture happens only while `mem_oe` is high.
- A falling chip select always coincides with `done`.
- A rejected request never raises chip select.
- The latched delay holds steady for as long as an access runs.
- Each read word follows a capture.
- The beat counter never moves by itself once it reaches zero.

The exact cycle counts per delay code, the beat count for each bus width, the half-word order and the one-cycle turnaround between back-to-back accesses depend on a whole access. The bench shows these by running complete accesses. It also shows that configuration changes made during an access are ignored.

// File: rtl/smc_seq_pkg.sv
`timescale 1ns/1ps
package smc_seq_pkg;

  localparam int CODE_W = 4;
  localparam int DLY_W  = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_GAP  = 2'd2,
    ST_TURN = 2'd3
  } seq_state_e;

  // Non-linear delay table: identity through 11, stretched above.
  function automatic logic [DLY_W-1:0] decode_delay(input logic [CODE_W-1:0] code);
    logic [DLY_W-1:0] d;
    if (code < CODE_W'(12)) begin
      d = DLY_W'(code);
    end else begin
      case (code[1:0])
        2'd0:    d = DLY_W'(13);
        2'd1:    d = DLY_W'(15);
        2'd2:    d = DLY_W'(18);
        default: d = DLY_W'(23);
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/smc_dly_decode.sv
`timescale 1ns/1ps
module smc_dly_decode
  import smc_seq_pkg::*;
#(
  parameter int MIN_VL_CODE = 3
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              var_lat_i,
  output logic [DLY_W-1:0]  dly_o,
  output logic              err_o
);

  always_comb begin
    dly_o = decode_delay(code_i);
    err_o = var_lat_i && (code_i < CODE_W'(MIN_VL_CODE));
  end

  // R1: decoded delay never shrinks below the code and is stretched above 11
  always_comb begin
    a_r1_decode_range: assert ((dly_o >= DLY_W'(code_i)) &&
                               ((code_i < CODE_W'(12)) || (dly_o > DLY_W'(code_i))) &&
                               (dly_o <= DLY_W'(23)));
  end

endmodule

// File: rtl/smc_beat_timer.sv
`timescale 1ns/1ps
module smc_beat_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  input  logic          run_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (run_i && (cnt_q != '0));
    cnt_d  = load_i ? val_i : (cnt_q - CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R3: an expired count stays at zero until reloaded
  a_r3_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && (cnt_q == '0)) |=> (cnt_q == '0));

endmodule

// File: rtl/smc_rd_assemble.sv
`timescale 1ns/1ps
module smc_rd_assemble #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic              narrow_i,
  input  logic              half_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int HW = DATA_W / 2;

  logic [HW-1:0]     lo_q,   lo_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic              vld_q,  vld_d;
  logic              lo_en,  word_en;

  always_comb begin
    lo_en   = cap_i && narrow_i && !half_i;
    word_en = cap_i && (!narrow_i || half_i);
    lo_d    = rdata_i[HW-1:0];
    word_d  = narrow_i ? {rdata_i[HW-1:0], lo_q} : rdata_i;
    vld_d   = word_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (lo_en)   lo_q   <= lo_d;
      if (word_en) word_q <= word_d;
    end
  end

  assign valid_o = vld_q;
  assign data_o  = word_q;

  // R9: a word is only presented after a capture
  a_r9_valid_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(cap_i));

endmodule

// File: rtl/smc_access_seq.sv
`timescale 1ns/1ps
module smc_access_seq
  import smc_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        cfg_dly_code,
  input  logic              cfg_narrow,
  input  logic              cfg_var_lat,
  input  logic              req_start,
  input  logic              req_write,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_cs,
  output logic              mem_oe,
  output logic              mem_we,
  output logic              mem_capture,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              cfg_err,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);

  localparam int BW = LEN_W + 1;
  localparam int HW = DATA_W / 2;

  seq_state_e        state_q, state_d;
  logic [DLY_W-1:0]  dly_q;
  logic              wr_q, vl_q, nar_q;
  logic [BW-1:0]     left_q, left_d;
  logic [BW-1:0]     idx_q, idx_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q;
  logic              err_q, err_d;

  logic [DLY_W-1:0]  dec_dly;
  logic              dec_err;
  logic              accept, start_ok, beat_end, last_beat, gap_mode;
  logic              tmr_load, tmr_zero;
  logic [DLY_W-1:0]  tmr_val;
  logic [BW-1:0]     tot_m1;
  logic              beat_en;

  smc_dly_decode #(.MIN_VL_CODE(3)) u_decode (
    .code_i    (cfg_dly_code),
    .var_lat_i (cfg_var_lat),
    .dly_o     (dec_dly),
    .err_o     (dec_err)
  );

  // ---- request acceptance and beat bookkeeping ----
  always_comb begin
    accept    = req_start && ((state_q == ST_IDLE) || (state_q == ST_TURN));
    start_ok  = accept && !dec_err;
    gap_mode  = wr_q || vl_q;
    last_beat = (left_q == '0);
    beat_end  = (state_q == ST_BEAT) && tmr_zero;
    beat_en   = start_ok || beat_end;
    err_d     = accept && dec_err;

    if (req_write)       tot_m1 = BW'(cfg_narrow);
    else if (cfg_narrow) tot_m1 = {req_len, 1'b1};
    else                 tot_m1 = {1'b0, req_len};

    left_d = start_ok ? tot_m1 : (left_q - BW'(1));
    idx_d  = start_ok ? '0 : (idx_q + BW'(1));
    addr_d = start_ok ? req_addr
                      : (addr_q + (nar_q ? ADDR_W'(2) : ADDR_W'(4)));
  end

  // ---- beat timer control ----
  always_comb begin
    tmr_load = start_ok ||
               (beat_end && !last_beat && !gap_mode) ||
               (state_q == ST_GAP);
    if (start_ok)
      tmr_val = (!req_write && !cfg_var_lat) ? (dec_dly + DLY_W'(1)) : dec_dly;
    else
      tmr_val = dly_q;
  end

  smc_beat_timer #(.CW(DLY_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .run_i  (state_q == ST_BEAT),
    .zero_o (tmr_zero)
  );

  // ---- next state ----
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_TURN: state_d = start_ok ? ST_BEAT : ST_IDLE;
      ST_BEAT: begin
        if (beat_end) begin
          if (last_beat)     state_d = ST_TURN;
          else if (gap_mode) state_d = ST_GAP;
          else               state_d = ST_BEAT;
        end
      end
      ST_GAP:  state_d = ST_BEAT;
      default: state_d = ST_IDLE;
    endcase
  end

  // ---- registers ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      dly_q   <= '0;
      wr_q    <= 1'b0;
      vl_q    <= 1'b0;
      nar_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (start_ok) begin
        dly_q   <= dec_dly;
        wr_q    <= req_write;
        vl_q    <= cfg_var_lat;
        nar_q   <= cfg_narrow;
        wdata_q <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      idx_q  <= '0;
      addr_q <= '0;
    end else if (beat_en) begin
      idx_q  <= idx_d;
      addr_q <= addr_d;
      if (start_ok || !last_beat) left_q <= left_d;
    end
  end

  // ---- read word assembly ----
  smc_rd_assemble #(.DATA_W(DATA_W)) u_rdasm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_i    (mem_capture),
    .narrow_i (nar_q),
    .half_i   (idx_q[0]),
    .rdata_i  (mem_rdata),
    .valid_o  (rd_valid),
    .data_o   (rd_data)
  );

  // ---- outputs ----
  always_comb begin
    mem_cs      = (state_q == ST_BEAT) || (state_q == ST_GAP);
    mem_oe      = !wr_q && (state_q == ST_BEAT);
    mem_we      = wr_q && (state_q == ST_BEAT);
    mem_capture = !wr_q && beat_end;
    mem_addr    = addr_q;
    done        = (state_q == ST_TURN);
    cfg_err     = err_q;
    if (nar_q)
      mem_wdata = {{(DATA_W-HW){1'b0}}, (idx_q[0] ? wdata_q[DATA_W-1:HW] : wdata_q[HW-1:0])};
    else
      mem_wdata = wdata_q;
  end

  // ---- assertions ----
  // R4: read and write strobes are exclusive
  a_r4_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_oe && mem_we));

  // R5: strobes only inside chip select
  a_r5_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_oe || mem_we) |-> mem_cs);

  // R2: data is only captured while output enable is driven
  a_r2_cap_in_oe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_capture |-> mem_oe);

  // R8: chip select ends together with the done pulse
  a_r8_cs_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs) |-> done);

  // R6: a rejected request leaves chip select low
  a_r6_err_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !mem_cs);

  // R10: latched timing holds while an access runs
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs && $past(mem_cs)) |-> ($stable(dly_q) && $stable(wr_q) && $stable(nar_q)));

endmodule

// File: tb/smc_access_seq_bench.sv
`timescale 1ns/1ps
module smc_access_seq_bench;

  localparam int AW = 24;
  localparam int DW = 32;
  localparam int LW = 4;

  logic          clk;
  logic          rst_n;
  logic [3:0]    cfg_dly_code;
  logic          cfg_narrow, cfg_var_lat;
  logic          req_start, req_write;
  logic [LW-1:0] req_len;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [DW-1:0] mem_rdata;
  logic          mem_cs, mem_oe, mem_we, mem_capture;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          cfg_err, rd_valid, done;
  logic [DW-1:0] rd_data;

  int  checks;
  int  failures;
  bit  finished;
  bit  tb_nar;

  smc_access_seq #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW)) u_smc_access_seq (
    .clk (clk), .rst_n (rst_n),
    .cfg_dly_code (cfg_dly_code), .cfg_narrow (cfg_narrow), .cfg_var_lat (cfg_var_lat),
    .req_start (req_start), .req_write (req_write), .req_len (req_len),
    .req_addr (req_addr), .req_wdata (req_wdata), .mem_rdata (mem_rdata),
    .mem_cs (mem_cs), .mem_oe (mem_oe), .mem_we (mem_we), .mem_capture (mem_capture),
    .mem_addr (mem_addr), .mem_wdata (mem_wdata), .cfg_err (cfg_err),
    .rd_valid (rd_valid), .rd_data (rd_data), .done (done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] lo_pat(input logic [AW-1:0] a);
    return a[15:0] ^ 16'h3C00;
  endfunction

  always_comb begin
    if (tb_nar) mem_rdata = {16'hDEAD, lo_pat(mem_addr)};
    else        mem_rdata = {mem_addr[15:0] ^ 16'h5A5A, lo_pat(mem_addr)};
  end

  function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] base, input int j, input bit nar);
    logic [AW-1:0] a;
    a = base + AW'(4 * j);
    if (nar) return {lo_pat(a + AW'(2)), lo_pat(a)};
    return {a[15:0] ^ 16'h5A5A, lo_pat(a)};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // {write, var_lat, narrow, code[3:0], len_m1[3:0], decoded delay[4:0]}
  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 4'd0,  4'd0, 5'd0},
    {1'b0, 1'b0, 1'b0, 4'd5,  4'd3, 5'd5},
    {1'b0, 1'b0, 1'b1, 4'd2,  4'd1, 5'd2},
    {1'b0, 1'b1, 1'b0, 4'd3,  4'd2, 5'd3},
    {1'b0, 1'b1, 1'b1, 4'd4,  4'd0, 5'd4},
    {1'b1, 1'b0, 1'b0, 4'd11, 4'd0, 5'd11},
    {1'b1, 1'b0, 1'b1, 4'd12, 4'd5, 5'd13},
    {1'b1, 1'b1, 1'b0, 4'd13, 4'd0, 5'd15},
    {1'b1, 1'b0, 1'b0, 4'd14, 4'd0, 5'd18},
    {1'b0, 1'b0, 1'b0, 4'd15, 4'd0, 5'd23},
    {1'b1, 1'b1, 1'b1, 4'd7,  4'd0, 5'd7},
    {1'b0, 1'b0, 1'b1, 4'd12, 4'd0, 5'd13}
  };

  task automatic run_vec(input int vi);
    logic [15:0]   v;
    bit            w, vl, nar;
    int            d, nb, len, exp_cs, exp_str, exp_first;
    int            cs_n, str_n, first_cap, cap_n, we_pulses, wcnt, done_k, bad_data, bad_addr;
    bit            we_prev;
    logic [AW-1:0] base;
    logic [DW-1:0] wd;
    v   = VEC[vi];
    w   = v[15]; vl = v[14]; nar = v[13];
    len = int'(v[8:5]);
    d   = int'(v[4:0]);
    base = AW'(24'h001000 + vi * 64);
    wd   = {16'hB000 + 16'(vi), 16'h0A00 + 16'(vi)};
    nb   = w ? (nar ? 2 : 1) : (len + 1) * (nar ? 2 : 1);
    if (!w && !vl) begin
      exp_cs = d + 2 + (nb - 1) * (d + 1); exp_str = exp_cs; exp_first = d + 2;
    end else begin
      exp_cs = nb * (d + 1) + nb - 1; exp_str = nb * (d + 1); exp_first = w ? 0 : d + 1;
    end
    @(negedge clk);
    tb_nar = nar;
    cfg_dly_code = v[12:9]; cfg_narrow = nar; cfg_var_lat = vl;
    req_write = w; req_len = v[8:5]; req_addr = base; req_wdata = wd; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    cs_n = 0; str_n = 0; first_cap = 0; cap_n = 0; we_pulses = 0; wcnt = 0;
    done_k = 0; bad_data = 0; bad_addr = 0; we_prev = 1'b0;
    for (int k = 1; k < 400; k++) begin
      cs_n  += int'(mem_cs);
      str_n += int'(mem_oe | mem_we);
      if (mem_capture) begin
        if (first_cap == 0) first_cap = k;
        if (mem_addr != base + AW'(cap_n * (nar ? 2 : 4))) bad_addr++;
        cap_n++;
      end
      if (mem_we && !we_prev) we_pulses++;
      if (mem_we) begin
        if (nar) begin
          if (mem_wdata != {16'h0, (we_pulses == 1) ? wd[15:0] : wd[31:16]}) bad_data++;
        end else if (mem_wdata != wd) bad_data++;
      end
      we_prev = mem_we;
      if (rd_valid) begin
        if (rd_data != exp_word(base, wcnt, nar)) bad_data++;
        wcnt++;
      end
      if (done) begin done_k = k; break; end
      @(negedge clk);
    end
    // R1 R2 R3 R4 R5: chip-select span follows decoded delay
    chk(cs_n == exp_cs, $sformatf("R1 vec%0d cs cycles", vi), cs_n, exp_cs);
    chk(str_n == exp_str, $sformatf("R5 vec%0d strobe cycles", vi), str_n, exp_str);
    chk(first_cap == exp_first, $sformatf("R2 vec%0d first capture cycle", vi), first_cap, exp_first);
    if (w) chk(we_pulses == nb && cap_n == 0, $sformatf("R4 vec%0d write beats", vi), we_pulses, nb);
    else   chk(cap_n == nb && wcnt == len + 1 && bad_addr == 0,
               $sformatf("R7 vec%0d read beats", vi), cap_n, nb);
    chk(done_k == exp_cs + 1, $sformatf("R8 vec%0d done cycle", vi), done_k, exp_cs + 1);
    chk(bad_data == 0, $sformatf("R9 vec%0d data mismatches", vi), bad_data, 0);
  endtask

  initial begin
    checks = 0; failures = 0; finished = 1'b0; tb_nar = 1'b0;
    rst_n = 1'b0; req_start = 1'b0; req_write = 1'b0; req_len = '0;
    req_addr = '0; req_wdata = '0; cfg_dly_code = 4'd0; cfg_narrow = 1'b0; cfg_var_lat = 1'b0;
    repeat (3) @(negedge clk);
    // R11: quiet outputs under reset
    chk({mem_cs, mem_oe, mem_we, mem_capture, rd_valid, done, cfg_err} == 7'b0,
        "R11 reset outputs", {mem_cs, mem_oe, mem_we, mem_capture, rd_valid, done, cfg_err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R6: variable-latency code 2 is rejected
    @(negedge clk);
    cfg_var_lat = 1'b1; cfg_dly_code = 4'd2; req_write = 1'b0; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    chk(cfg_err == 1'b1, "R6 err pulse", cfg_err, 1);
    chk(mem_cs == 1'b0, "R6 cs low on reject", mem_cs, 0);
    @(negedge clk);
    chk(cfg_err == 1'b0 && mem_cs == 1'b0 && done == 1'b0, "R6 err single cycle", cfg_err, 0);

    // R10: changes during an access are ignored
    begin
      int cs_n, cap_k, done_k;
      bit data_ok;
      tb_nar = 1'b0;
      cfg_var_lat = 1'b0; cfg_narrow = 1'b0; cfg_dly_code = 4'd1;
      req_write = 1'b0; req_len = '0; req_addr = 24'h002000; req_start = 1'b1;
      @(negedge clk);
      cfg_dly_code = 4'd15; cfg_var_lat = 1'b1; cfg_narrow = 1'b1;
      req_addr = 24'h00F000; req_write = 1'b1; req_len = 4'd7;
      cs_n = 0; cap_k = 0; done_k = 0; data_ok = 1'b0;
      for (int k = 1; k < 40; k++) begin
        if (k == 2) req_start = 1'b0;
        cs_n += int'(mem_cs);
        if (mem_capture && cap_k == 0) cap_k = k;
        if (rd_valid) data_ok = (rd_data == exp_word(24'h002000, 0, 1'b0));
        if (done) begin done_k = k; break; end
        @(negedge clk);
      end
      chk(cs_n == 3, "R10 cs cycles with live changes", cs_n, 3);
      chk(cap_k == 3, "R10 capture cycle", cap_k, 3);
      chk(done_k == 4 && data_ok, "R10 done and data", done_k, 4);
      cs_n = 0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        cs_n += int'(mem_cs);
      end
      chk(cs_n == 0, "R10 busy request not queued", cs_n, 0);
    end

    // R8: back-to-back accesses leave one cycle of chip select low
    cfg_var_lat = 1'b0; cfg_narrow = 1'b0; cfg_dly_code = 4'd0;
    req_write = 1'b1; req_wdata = 32'h1234_5678; req_addr = 24'h000400; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    @(negedge clk);
    chk(done == 1'b1 && mem_cs == 1'b0, "R8 done cycle cs low", {done, mem_cs}, 2);
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    chk(mem_cs == 1'b1 && mem_we == 1'b1, "R8 second access starts next cycle", mem_cs, 1);
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule